// File: doc/BRIEF.md
# Board Control Register Block

A small memory-mapped register file for board support, attached to a simple 32-bit register bus made of an address, a write enable, write data and combinational read data. It exposes two fixed identification words (a build identifier and the processor clock frequency in Hz), a read/write LED output register and a read-only view of the DIP switch inputs.

A write of one magic value to the reset register produces a one-cycle request to the system reset sequencer. Only the low 16 address bits are decoded, so the block occupies a 64 KiB window. Any offset without a register reads as zero and ignores writes. Switch inputs are asynchronous to the bus clock and pass through a two-flop synchroniser before software can see them.

Top module: `board_ctl`

## Requirements
- R1: A read at offset 0x0 returns the build identifier parameter, 32'h09272011 by default.
- R2: A read at offset 0x4 returns the clock-frequency parameter, 10000000 by default.
- R3: A write at offset 0x8 stores wdata_i[LED_W-1:0] at the clock edge. `led_o` then drives the stored value, with 1 meaning LED on. A read at 0x8 returns it zero-extended, and the write-data bits above LED_W are dropped.
- R4: A read at offset 0xC returns the switch inputs zero-extended, with 1 meaning switch on. A change on `sw_i` becomes readable after the second rising clock edge that follows it, and not after the first.
- R5: A write of exactly 32'h0000DEAD at offset 0x10 drives `rst_req_o` high during the clock cycle after the write edge only. A write of any other value at 0x10 leaves `rst_req_o` low.
- R6: Every offset other than 0x0, 0x4, 0x8 and 0xC reads zero, offset 0x10 included. Writes to those offsets, and writes to 0x0, 0x4 and 0xC, change no register and no output.
- R7: Only addr_i[15:0] is decoded, so any value of the upper address bits reaches the same register.
- R8: While `rst_ni` is low, the LED register, the switch synchroniser and `rst_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address; the low 16 bits select the register |
| we_i | input | 1 | Write enable, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| led_o | output | LED_W | LED drive, 1 = on |
| sw_i | input | SW_W | Asynchronous DIP switch inputs, 1 = on |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check three things on every cycle. The decoder selects at most one register. The LED register loads on a write to its offset and holds at all other times. The reset request rises only after a magic write to the reset offset and always follows one. Only the bench scenarios can show that the fixed words and the zero fill read correctly across the swept offsets and upper-address aliases. The same goes for the two-edge latency of the switch path and the rejection of near-miss magic values.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned NREG   = 5;

  // index * 4 gives the byte offset; software relies on these positions
  typedef enum logic [2:0] {
    REG_ID  = 3'd0,
    REG_CLK = 3'd1,
    REG_LED = 3'd2,
    REG_SW  = 3'd3,
    REG_RST = 3'd4
  } reg_e;

  localparam logic [DATA_W-1:0] RST_MAGIC = 32'h0000_DEAD;

  function automatic logic [OFF_W-1:0] reg_offset(input int unsigned idx);
    return OFF_W'(idx * 4);
  endfunction
endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output logic [NREG-1:0]  sel_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel_o[g] = (off_i == reg_offset(g));
  end
endmodule

// File: rtl/board_ctl_sync.sv
module board_ctl_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/board_ctl_rst_trig.sv
module board_ctl_rst_trig
  import board_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o
);
  logic fire;
  assign fire = we_i & sel_i & (wdata_i == RST_MAGIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= fire;
  end

  // R5: a request is always preceded by a qualifying write
  a_r5_req_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(we_i && sel_i && wdata_i == RST_MAGIC));
endmodule

// File: rtl/board_ctl.sv
module board_ctl
  import board_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       LED_W    = 8,
  parameter int unsigned       SW_W     = 8,
  parameter logic [DATA_W-1:0] BUILD_ID = 32'h0927_2011,
  parameter logic [DATA_W-1:0] CLK_HZ   = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LED_W-1:0]  led_o,
  input  logic [SW_W-1:0]   sw_i,
  output logic              rst_req_o
);
  localparam int unsigned HI_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] off;
  logic [NREG-1:0]  sel;
  logic [SW_W-1:0]  sw_sync;
  logic [LED_W-1:0] led_q;
  logic [DATA_W-1:0] rd_word [NREG];

  assign off = addr_i[OFF_W-1:0];
  if (HI_W > 0) begin : g_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:OFF_W];
  end

  board_ctl_decode u_dec (.off_i(off), .sel_o(sel));

  board_ctl_sync #(.W(SW_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_i), .q_o(sw_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 led_q <= '0;
    else if (we_i && sel[REG_LED]) led_q <= wdata_i[LED_W-1:0];
  end
  assign led_o = led_q;

  board_ctl_rst_trig u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
    .sel_i(sel[REG_RST]), .wdata_i(wdata_i), .req_o(rst_req_o)
  );

  assign rd_word[REG_ID]  = BUILD_ID;
  assign rd_word[REG_CLK] = CLK_HZ;
  assign rd_word[REG_LED] = DATA_W'(led_q);
  assign rd_word[REG_SW]  = DATA_W'(sw_sync);
  assign rd_word[REG_RST] = '0;

  // AND-OR read mux; no select -> zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rdata_o |= rd_word[i];
  end

  // R6: decode never selects two registers
  a_r6_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  // R3: LED loads from a write at offset 0x8
  a_r3_led_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[OFF_W-1:0] == 16'h0008) |=> led_o == $past(wdata_i[LED_W-1:0]));
  // R3/R6: LED holds without such a write
  a_r3_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[OFF_W-1:0] == 16'h0008) |=> $stable(led_o));
  // R5: magic write always produces the request
  a_r5_magic_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[OFF_W-1:0] == 16'h0010 && wdata_i == 32'h0000_DEAD) |=> rst_req_o);
endmodule

// File: tb/board_ctl_test.sv
module board_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  led;
  logic [7:0]  sw = '0;
  logic        req;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [7:0] exp_led = '0;
  logic [7:0] exp_sw = '0;

  always #4 clk = ~clk;

  board_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .led_o(led), .sw_i(sw), .rst_req_o(req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [15:0] off);
    case (off)
      16'h0000: return 32'h0927_2011;
      16'h0004: return 32'd10_000_000;
      16'h0008: return {24'b0, exp_led};
      16'h000C: return {24'b0, exp_sw};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic rd_chk(input string tag, input logic [31:0] a);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 chk(tag, rdata, exp_read(a[15:0]));
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    // R8: reset state
    #20;
    chk("R8 led", {24'b0, led}, 32'h0);
    chk("R8 req", {31'b0, req}, 32'h0);
    addr = 32'h8; #1 chk("R8 led read", rdata, 32'h0);
    sw = 8'hA5; addr = 32'hC; #10 chk("R8 sync held", rdata, 32'h0);
    sw = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R6 R7: sweep byte offsets with several upper-address patterns
    for (int h = 0; h < 4; h++) begin
      for (int o = 0; o < 64; o++) begin
        logic [31:0] a;
        a = {16'(h * 16'h5A3C), 16'(o)};
        rd_chk("R1/R2/R6/R7 read sweep", a);
      end
    end
    rd_chk("R6 top of window", 32'h0000_FFFC);
    rd_chk("R7 id alias", 32'hFFFF_0000);

    // R3: every LED pattern, upper write bits dropped
    for (int v = 0; v < 256; v++) begin
      wr(32'h8 | (32'(v) << 16), {24'hC3A5F0, 8'(v)});
      exp_led = 8'(v);
      chk("R3 led_o", {24'b0, led}, {24'b0, exp_led});
      rd_chk("R3 readback", 32'h8);
    end
    wr(32'h8, 32'h0000_005A); exp_led = 8'h5A;

    // R6: writes to other offsets leave everything unchanged
    for (int o = 0; o < 64; o += 4) begin
      if (o == 8 || o == 16) continue;
      wr(32'(o), 32'hFFFF_FFFF);
      chk("R6 led after stray write", {24'b0, led}, {24'b0, exp_led});
      chk("R6 no req", {31'b0, req}, 32'h0);
    end
    rd_chk("R6 id unchanged", 32'h0);
    rd_chk("R6 clk unchanged", 32'h4);
    rd_chk("R6 led unchanged", 32'h8);

    // R4: switch sweep with two-edge latency
    for (int v = 1; v < 256; v++) begin
      @(negedge clk); sw = 8'(v); addr = 32'hC;
      @(negedge clk); #1 chk("R4 not after one edge", rdata, {24'b0, exp_sw});
      @(negedge clk); exp_sw = 8'(v);
      #1 chk("R4 after two edges", rdata, {24'b0, exp_sw});
    end
    wr(32'hC, 32'h0000_0000);
    rd_chk("R4 write to switch ignored", 32'hC);

    // R5: magic write gives one-cycle request
    wr(32'h10, 32'h0000_DEAD);
    #1 chk("R5 req high", {31'b0, req}, 32'h1);
    @(negedge clk); #1 chk("R5 req one cycle", {31'b0, req}, 32'h0);
    wr(32'hABCD_0010, 32'h0000_DEAD);
    #1 chk("R5/R7 req via alias", {31'b0, req}, 32'h1);
    @(negedge clk);
    rd_chk("R6 reset offset reads zero", 32'h10);
    // R5: near misses
    for (int b = 0; b < 32; b++) begin
      wr(32'h10, 32'h0000_DEAD ^ (32'h1 << b));
      #1 chk("R5 near miss no req", {31'b0, req}, 32'h0);
    end
    wr(32'h14, 32'h0000_DEAD);
    #1 chk("R5 wrong offset no req", {31'b0, req}, 32'h0);
    wr(32'h11, 32'h0000_DEAD);
    #1 chk("R5 unaligned no req", {31'b0, req}, 32'h0);
    chk("R5 led untouched", {24'b0, led}, {24'b0, exp_led});

    // R8: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0; exp_led = '0; exp_sw = '0;
    #1 chk("R8 led cleared", {24'b0, led}, 32'h0);
    addr = 32'hC; #1 chk("R8 sw cleared", rdata, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule